// File: doc/BRIEF.md
# Thermal Alarm Register and Event Controller

This block is the register and event core of a thermal sensor that sits on a memory module. A converter outside the block delivers signed temperature samples. The block keeps the latest sample, compares it against an upper and a lower alarm limit and a critical limit, and applies a programmable hysteresis. From the result it drives one event output.

The event output works in one of two modes. In level mode it follows the alarm condition. In latched mode it holds until software acknowledges it. A critical-only option can replace the window alarm with the critical trip alone. Software reaches every register through a small port. A 3-bit pointer is loaded first, and then data is written to or read from the register that the pointer selects. A write that arrives in the same cycle as a pointer load uses the old pointer. Two sticky lock bits protect the limits and the event settings from later changes.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset, the identity register (pointer 0) reads 0x0001. The settings register (1), the upper limit (2), the lower limit (3), the critical limit (4) and the temperature register (5) all read 0x0000. With the enable clear and the polarity low, the event output is high, which is its inactive level.
- R2: Pointer codes 6 and 7 read 0x0000. Writes to the identity register and to the temperature register have no effect.
- R3: A limit register keeps only bits [12:2] of the written word, with a 0.25 °C step. All other bits read back as zero. Comparisons use the limit shifted left by two bits, which puts it on the 0.0625 °C scale of the sample.
- R4: Each accepted sample is a 13-bit two's complement value with a 0.0625 °C step. The temperature register reads {critical, above, below, sample[12:0]}, with the critical flag in bit 15, the above flag in bit 14 and the below flag in bit 13.
- R5: The above flag sets when the sample is greater than the upper limit. It clears when the sample is less than the upper limit minus the hysteresis. Between those two points it holds.
- R6: The below flag sets when the sample is less than the lower limit minus the hysteresis. It clears when the sample is greater than or equal to the lower limit. Between those two points it holds.
- R7: The critical flag sets when the sample is greater than the critical limit. It clears when the sample is less than the critical limit minus the hysteresis.
- R8: Settings bits [10:9] choose the hysteresis. The code 00 gives 0, 01 gives 24 sample steps (1.5 °C), 10 gives 48 steps and 11 gives 96 steps.
- R9: In level mode (settings bit 0 = 0), the event is active exactly while any flag is set. Writing the acknowledge bit (settings bit 5) in this mode does nothing.
- R10: In latched mode (bit 0 = 1), the event sets when the window condition (above OR below) rises. It stays set until a write to the settings register with bit 5 = 1 clears it.
- R11: The critical flag always drives the event active, and acknowledge does not clear it. With critical-only set (bit 2), the window condition produces no event.
- R12: Bit 1 selects the polarity (1 = active high). Bit 3 enables the output; while it is clear, the output sits at its inactive level. Bit 4 reads back the internal event state and ignores writes.
- R13: Lock bits 6 (alarm) and 7 (critical) are sticky until reset. While either lock is set, bits 0 and 1 cannot change. The alarm lock freezes the upper and lower limits, and the critical lock freezes the critical limit.
- R14: While shutdown (bit 8) is set, samples are ignored, and the temperature register and its flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ptrWrEn | input | 1 | Load the pointer from ptrWrData |
| ptrWrData | input | 3 | New pointer value |
| regWrEn | input | 1 | Write regWrData to the register the pointer selects |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Contents of the register the pointer selects (combinational) |
| sampleValid | input | 1 | A new temperature sample is present |
| sampleTemp | input | 13 | Signed sample, 0.0625 °C step |
| eventOut | output | 1 | Event output after the enable and polarity settings |

## Verification
A table of samples is applied with 1.5 °C hysteresis. The samples step across each trip point, land exactly on a limit, stop inside each hysteresis band and include a negative value. This separates strict from non-strict comparisons and shows whether each flag holds or releases. Each of the other three hysteresis codes is then run through a set–hold–clear triple, whose middle sample falls inside only the correct band. Directed sequences cover the following:
- an acknowledge issued after the condition has gone away, and one issued while it persists, which separates a latch that sets on a rise from one that sets on a level;
- a critical trip that outlasts an acknowledge;
- lock and shutdown writes that must leave the readback unchanged.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam int DATA_W   = 16;
  localparam int TEMP_W   = 13;
  localparam int PTR_W    = 3;
  localparam int LIM_LO   = 2;
  localparam int LIM_W    = TEMP_W - LIM_LO;
  localparam int FLAG_W   = DATA_W - TEMP_W;
  localparam int EXT_W    = TEMP_W + 2;
  localparam int HYST_STEP = 24;

  localparam logic [DATA_W-1:0] IDENT_VALUE = 16'h0001;

  localparam logic [PTR_W-1:0] SEL_IDENT = 3'd0;
  localparam logic [PTR_W-1:0] SEL_CFG   = 3'd1;
  localparam logic [PTR_W-1:0] SEL_UPPER = 3'd2;
  localparam logic [PTR_W-1:0] SEL_LOWER = 3'd3;
  localparam logic [PTR_W-1:0] SEL_CRIT  = 3'd4;
  localparam logic [PTR_W-1:0] SEL_TEMP  = 3'd5;

  typedef struct packed {
    logic wrPtr;
    logic wrCfg;
    logic wrUpper;
    logic wrLower;
    logic wrCrit;
  } regStrobe_t;

  typedef struct packed {
    logic [1:0] hyst;
    logic       shutdown;
    logic       lockCrit;
    logic       lockAlarm;
    logic       outEn;
    logic       critOnly;
    logic       polHigh;
    logic       modeInt;
  } cfg_t;
endpackage

// File: rtl/thermal_datapath.sv
module thermal_datapath
  import thermal_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [PTR_W-1:0]    ptrWrData,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                sampleValid,
  input  logic [TEMP_W-1:0]   sampleTemp,
  input  logic                statusBit,
  output logic [PTR_W-1:0]    ptrQ,
  output cfg_t                cfgQ,
  output logic                critFlag,
  output logic                aboveFlag,
  output logic                belowFlag,
  output logic [DATA_W-1:0]   rdData
);
  logic [LIM_W-1:0]  upperQ, lowerQ, critQ;
  logic [TEMP_W-1:0] tempQ;
  logic              critF, aboveF, belowF;
  logic              unusedWr;

  logic signed [EXT_W-1:0] tExt, upExt, loExt, crExt, hystExt;
  logic signed [EXT_W-1:0] upRel, loRel, crRel;
  logic nxtAbove, nxtBelow, nxtCrit;

  assign unusedWr = ^{wrData[DATA_W-1:TEMP_W], wrData[11]};

  always_comb begin
    unique case (cfgQ.hyst)
      2'd0:    hystExt = '0;
      2'd1:    hystExt = EXT_W'(HYST_STEP);
      2'd2:    hystExt = EXT_W'(HYST_STEP * 2);
      default: hystExt = EXT_W'(HYST_STEP * 4);
    endcase
  end

  assign tExt  = {{(EXT_W-TEMP_W){sampleTemp[TEMP_W-1]}}, sampleTemp};
  assign upExt = {{(EXT_W-TEMP_W){upperQ[LIM_W-1]}}, upperQ, {LIM_LO{1'b0}}};
  assign loExt = {{(EXT_W-TEMP_W){lowerQ[LIM_W-1]}}, lowerQ, {LIM_LO{1'b0}}};
  assign crExt = {{(EXT_W-TEMP_W){critQ[LIM_W-1]}}, critQ, {LIM_LO{1'b0}}};
  assign upRel = upExt - hystExt;
  assign loRel = loExt - hystExt;
  assign crRel = crExt - hystExt;

  always_comb begin
    nxtAbove = aboveF;
    if (tExt > upExt)      nxtAbove = 1'b1;
    else if (tExt < upRel) nxtAbove = 1'b0;
    nxtBelow = belowF;
    if (tExt < loRel)       nxtBelow = 1'b1;
    else if (tExt >= loExt) nxtBelow = 1'b0;
    nxtCrit = critF;
    if (tExt > crExt)      nxtCrit = 1'b1;
    else if (tExt < crRel) nxtCrit = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      cfgQ   <= '0;
      upperQ <= '0;
      lowerQ <= '0;
      critQ  <= '0;
      tempQ  <= '0;
      critF  <= 1'b0;
      aboveF <= 1'b0;
      belowF <= 1'b0;
    end else begin
      if (strobe.wrPtr) ptrQ <= ptrWrData;
      if (strobe.wrCfg) begin
        cfgQ.lockAlarm <= cfgQ.lockAlarm | wrData[6];
        cfgQ.lockCrit  <= cfgQ.lockCrit  | wrData[7];
        if (!(cfgQ.lockAlarm || cfgQ.lockCrit)) begin
          cfgQ.modeInt <= wrData[0];
          cfgQ.polHigh <= wrData[1];
        end
        cfgQ.critOnly <= wrData[2];
        cfgQ.outEn    <= wrData[3];
        cfgQ.shutdown <= wrData[8];
        cfgQ.hyst     <= wrData[10:9];
      end
      if (strobe.wrUpper && !cfgQ.lockAlarm) upperQ <= wrData[TEMP_W-1:LIM_LO];
      if (strobe.wrLower && !cfgQ.lockAlarm) lowerQ <= wrData[TEMP_W-1:LIM_LO];
      if (strobe.wrCrit  && !cfgQ.lockCrit)  critQ  <= wrData[TEMP_W-1:LIM_LO];
      if (sampleValid && !cfgQ.shutdown) begin
        tempQ  <= sampleTemp;
        aboveF <= nxtAbove;
        belowF <= nxtBelow;
        critF  <= nxtCrit;
      end
    end
  end

  assign critFlag  = critF;
  assign aboveFlag = aboveF;
  assign belowFlag = belowF;

  always_comb begin
    unique case (ptrQ)
      SEL_IDENT: rdData = IDENT_VALUE;
      SEL_CFG:   rdData = {5'b0, cfgQ.hyst, cfgQ.shutdown, cfgQ.lockCrit, cfgQ.lockAlarm,
                           1'b0, statusBit, cfgQ.outEn, cfgQ.critOnly, cfgQ.polHigh, cfgQ.modeInt};
      SEL_UPPER: rdData = {{FLAG_W{1'b0}}, upperQ, {LIM_LO{1'b0}}};
      SEL_LOWER: rdData = {{FLAG_W{1'b0}}, lowerQ, {LIM_LO{1'b0}}};
      SEL_CRIT:  rdData = {{FLAG_W{1'b0}}, critQ, {LIM_LO{1'b0}}};
      SEL_TEMP:  rdData = {critF, aboveF, belowF, tempQ};
      default:   rdData = '0;
    endcase
  end

  AST_ALARM_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.lockAlarm |=> $stable(upperQ) && $stable(lowerQ)); // R13
  AST_CRIT_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.lockCrit |=> $stable(critQ)); // R13
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.lockAlarm || cfgQ.lockCrit) |=> $stable(cfgQ.modeInt) && $stable(cfgQ.polHigh) && cfgQ.lockAlarm == $past(cfgQ.lockAlarm) | cfgQ.lockAlarm); // R13
  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.shutdown |=> $stable(tempQ) && $stable({critF, aboveF, belowF})); // R14
endmodule

// File: rtl/thermal_control.sv
module thermal_control
  import thermal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ptrWrEn,
  input  logic             regWrEn,
  input  logic             ackBit,
  input  logic [PTR_W-1:0] ptrQ,
  input  logic             modeInt,
  input  logic             polHigh,
  input  logic             critOnly,
  input  logic             outEn,
  input  logic             critFlag,
  input  logic             aboveFlag,
  input  logic             belowFlag,
  output regStrobe_t       strobe,
  output logic             eventActive,
  output logic             eventOut
);
  logic winCond, prevWin, latchQ, winRise, clrStrobe;

  always_comb begin
    strobe.wrPtr   = ptrWrEn;
    strobe.wrCfg   = regWrEn && (ptrQ == SEL_CFG);
    strobe.wrUpper = regWrEn && (ptrQ == SEL_UPPER);
    strobe.wrLower = regWrEn && (ptrQ == SEL_LOWER);
    strobe.wrCrit  = regWrEn && (ptrQ == SEL_CRIT);
  end

  assign winCond   = aboveFlag | belowFlag;
  assign winRise   = modeInt && !critOnly && winCond && !prevWin;
  assign clrStrobe = strobe.wrCfg && ackBit && modeInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWin <= 1'b0;
      latchQ  <= 1'b0;
    end else begin
      prevWin <= winCond;
      if (winRise)        latchQ <= 1'b1;
      else if (clrStrobe) latchQ <= 1'b0;
    end
  end

  assign eventActive = critFlag | (!critOnly & (modeInt ? latchQ : winCond));
  assign eventOut    = (outEn && eventActive) ? polHigh : !polHigh;

  AST_CRIT_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    (critFlag && outEn) |-> (eventOut == polHigh)); // R11
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && !clrStrobe) |=> latchQ); // R10
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrWrEn,
  input  logic [PTR_W-1:0]  ptrWrData,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  output logic              eventOut
);
  regStrobe_t       strobe;
  cfg_t             cfgQ;
  logic [PTR_W-1:0] ptrQ;
  logic             critFlag, aboveFlag, belowFlag, eventActive;

  thermal_control uCtrl (
    .clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .regWrEn(regWrEn),
    .ackBit(regWrData[5]), .ptrQ(ptrQ),
    .modeInt(cfgQ.modeInt), .polHigh(cfgQ.polHigh),
    .critOnly(cfgQ.critOnly), .outEn(cfgQ.outEn),
    .critFlag(critFlag), .aboveFlag(aboveFlag), .belowFlag(belowFlag),
    .strobe(strobe), .eventActive(eventActive), .eventOut(eventOut)
  );

  thermal_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptrWrData(ptrWrData),
    .wrData(regWrData), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .statusBit(eventActive), .ptrQ(ptrQ), .cfgQ(cfgQ),
    .critFlag(critFlag), .aboveFlag(aboveFlag), .belowFlag(belowFlag),
    .rdData(regRdData)
  );
endmodule

// File: tb/tb_thermal_alarm_ctrl.sv
module tb_thermal_alarm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // sample and expected {crit, above, below}; upper 30C, lower 10C, crit 50C, hyst 1.5C
  localparam logic [12:0] VEC_T [NVEC] = '{13'd320, 13'd481, 13'd470, 13'd455, 13'd480,
    13'd160, 13'd140, 13'd135, 13'd150, 13'd160, 13'd801, 13'd790, 13'd775, 13'h1FE0, 13'd0};
  localparam logic [2:0] VEC_F [NVEC] = '{3'b000, 3'b010, 3'b010, 3'b000, 3'b000,
    3'b000, 3'b000, 3'b001, 3'b001, 3'b000, 3'b110, 3'b110, 3'b010, 3'b001, 3'b001};

  logic clk = 1'b0, rstN = 1'b0;
  logic ptrWrEn = 1'b0, regWrEn = 1'b0, sampleValid = 1'b0;
  logic [2:0]  ptrWrData = '0;
  logic [15:0] regWrData = '0, regRdData;
  logic [12:0] sampleTemp = '0;
  logic eventOut;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [15:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_alarm_ctrl dut (.clk(clk), .rstN(rstN), .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .sampleValid(sampleValid), .sampleTemp(sampleTemp), .eventOut(eventOut));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] p, input logic [15:0] d);
    @(negedge clk); ptrWrEn = 1'b1; ptrWrData = p;
    @(negedge clk); ptrWrEn = 1'b0; regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
    @(negedge clk);
  endtask

  task automatic doRead(input logic [2:0] p, output logic [15:0] d);
    @(negedge clk); ptrWrEn = 1'b1; ptrWrData = p;
    @(negedge clk); ptrWrEn = 1'b0; d = regRdData;
  endtask

  task automatic doSample(input logic [12:0] t);
    @(negedge clk); sampleValid = 1'b1; sampleTemp = t;
    @(negedge clk); sampleValid = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 event idle", {15'd0, eventOut}, 16'd1);
    doRead(3'd0, rd); check("R1 ident", rd, 16'h0001);
    doRead(3'd1, rd); check("R1 cfg", rd, 16'h0000);
    doRead(3'd2, rd); check("R1 upper", rd, 16'h0000);
    doRead(3'd3, rd); check("R1 lower", rd, 16'h0000);
    doRead(3'd4, rd); check("R1 crit", rd, 16'h0000);
    doRead(3'd5, rd); check("R1 temp", rd, 16'h0000);
    // R2 unused codes and read-only registers
    doRead(3'd6, rd); check("R2 code6", rd, 16'h0000);
    doRead(3'd7, rd); check("R2 code7", rd, 16'h0000);
    doWrite(3'd0, 16'hFFFF); doRead(3'd0, rd); check("R2 ident ro", rd, 16'h0001);
    doWrite(3'd5, 16'h1234); doRead(3'd5, rd); check("R2 temp ro", rd, 16'h0000);
    // R3 limit field
    doWrite(3'd2, 16'hFFFF); doRead(3'd2, rd); check("R3 unused bits", rd, 16'h1FFC);
    doWrite(3'd2, 16'h01E0); doWrite(3'd3, 16'h00A0); doWrite(3'd4, 16'h0320);
    doRead(3'd4, rd); check("R3 crit store", rd, 16'h0320);
    doWrite(3'd1, 16'h020A);
    // R4 R5 R6 R7 vector table, comparator mode R9
    for (int i = 0; i < NVEC; i++) begin
      doSample(VEC_T[i]);
      doRead(3'd5, rd);
      check($sformatf("R4/R5/R6/R7 vec%0d temp", i), rd, {VEC_F[i], VEC_T[i]});
      check($sformatf("R9 vec%0d event", i), {15'd0, eventOut}, {15'd0, |VEC_F[i]});
    end
    // R8 hysteresis codes
    doWrite(3'd1, 16'h040A);
    doSample(13'd490); doSample(13'd440); doRead(3'd5, rd); check("R8 h48 hold", {13'd0, rd[15:13]}, 16'd2);
    doSample(13'd431); doRead(3'd5, rd); check("R8 h48 clear", {13'd0, rd[15:13]}, 16'd0);
    doWrite(3'd1, 16'h060A);
    doSample(13'd490); doSample(13'd390); doRead(3'd5, rd); check("R8 h96 hold", {13'd0, rd[15:13]}, 16'd2);
    doSample(13'd383); doRead(3'd5, rd); check("R8 h96 clear", {13'd0, rd[15:13]}, 16'd0);
    doWrite(3'd1, 16'h000A);
    doSample(13'd490); doSample(13'd479); doRead(3'd5, rd); check("R8 h0 clear", {13'd0, rd[15:13]}, 16'd0);
    // R9 acknowledge ignored in comparator mode
    doWrite(3'd1, 16'h020A);
    doSample(13'd490); doWrite(3'd1, 16'h022A);
    check("R9 ack ignored", {15'd0, eventOut}, 16'd1);
    doSample(13'd320); check("R9 follows", {15'd0, eventOut}, 16'd0);
    // R10 interrupt latch
    doWrite(3'd1, 16'h020B);
    doSample(13'd490); check("R10 set", {15'd0, eventOut}, 16'd1);
    doSample(13'd320); check("R10 held", {15'd0, eventOut}, 16'd1);
    doWrite(3'd1, 16'h022B); check("R10 cleared", {15'd0, eventOut}, 16'd0);
    doRead(3'd1, rd); check("R10 cfg readback", rd, 16'h020B);
    doSample(13'd490); check("R10 new rise", {15'd0, eventOut}, 16'd1);
    doWrite(3'd1, 16'h022B); check("R10 clear while high", {15'd0, eventOut}, 16'd0);
    doSample(13'd320);
    // R11 critical only and critical override
    doWrite(3'd1, 16'h020E);
    doSample(13'd490); check("R11 window masked", {15'd0, eventOut}, 16'd0);
    doSample(13'd810); check("R11 crit trip", {15'd0, eventOut}, 16'd1);
    doWrite(3'd1, 16'h022B); check("R11 crit not cleared", {15'd0, eventOut}, 16'd1);
    doSample(13'd320); check("R11 crit released", {15'd0, eventOut}, 16'd0);
    // R12 polarity, enable, status
    doWrite(3'd1, 16'h0208);
    doSample(13'd490); check("R12 active low", {15'd0, eventOut}, 16'd0);
    doRead(3'd1, rd); check("R12 status", rd, 16'h0218);
    doWrite(3'd1, 16'h0200); check("R12 disabled low pol", {15'd0, eventOut}, 16'd1);
    doWrite(3'd1, 16'h0202); check("R12 disabled high pol", {15'd0, eventOut}, 16'd0);
    // R14 shutdown
    doRead(3'd5, rd); check("R14 before", rd, 16'h41EA);
    doWrite(3'd1, 16'h0302);
    doSample(13'd100); doRead(3'd5, rd); check("R14 held", rd, 16'h41EA);
    doWrite(3'd1, 16'h0202);
    doSample(13'd100); doRead(3'd5, rd); check("R14 resumed", rd, 16'h2064);
    // R13 locks
    doWrite(3'd1, 16'h024A);
    doWrite(3'd2, 16'h0100); doRead(3'd2, rd); check("R13 upper locked", rd, 16'h01E0);
    doWrite(3'd3, 16'h0100); doRead(3'd3, rd); check("R13 lower locked", rd, 16'h00A0);
    doWrite(3'd4, 16'h0400); doRead(3'd4, rd); check("R13 crit open", rd, 16'h0400);
    doWrite(3'd1, 16'h000B); doRead(3'd1, rd); check("R13 mode frozen", rd, 16'h005A);
    doWrite(3'd1, 16'h0088); doRead(3'd1, rd); check("R13 pol frozen", rd, 16'h00DA);
    doWrite(3'd4, 16'h0320); doRead(3'd4, rd); check("R13 crit locked", rd, 16'h0400);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule